// File: doc/BRIEF.md
# UART Line Status Unit

This block produces the eight-bit line status word and the transmit-empty interrupt request of a 16450/16550-style UART. It owns a small receive character queue. Each queue entry holds a received byte together with three error tags: parity, missing stop bit and break. The serial receiver pushes finished characters into the queue. The CPU pops them through a receive-data read strobe and clears the sticky status flags through a status-read strobe.

On the transmit side, the block follows the holding register (or the transmit FIFO) and the shift register to derive the two transmit status bits. A mode input selects the character mode, which uses a one-deep receive buffer and reads status bit 7 as zero, or the queued mode, which uses a sixteen-deep queue. In queued mode, bit 7 summarises the errors of all queued characters, and the per-character error bits follow the character at the head of the queue.

Top module: `lsr_unit`

## Requirements
- R1: Status bit 0 is 1 exactly when the receive queue holds at least one unread character. It drops when the last character is read through `rbr_rd`.
- R2: A character that arrives while the queue is full (16 entries in queued mode, 1 in character mode) is discarded and sets bit 1. A status read clears bit 1. If a new overrun happens in the same cycle as the read, the set wins.
- R3: Bits 2 (parity error), 3 (missing stop bit) and 4 (break) take the tags of a character when it reaches the head of the queue. They stay set until a status read. If a new head event happens in the same cycle as the read, the set wins.
- R4: Bit 7 reads 0 in character mode. In queued mode it is 1 while any queued entry carries a tag. A status read clears it only when no tagged entry remains.
- R5: Bit 5 (transmit holding empty) is 1 after reset. In character mode it sets on a `thr_to_tsr` pulse. In queued mode it sets when `tx_fifo_empty` rises. A `thr_wr` clears it, and the clear has priority.
- R6: Bit 6 is 1 when the shift register is empty and also either the holding register is empty (character mode) or the transmit FIFO is empty (queued mode).
- R7: `thre_irq` is raised in the cycle after bit 5 goes from 0 to 1 while `ier_thre` is 1. A `thr_wr` or a low `ier_thre` clears it.
- R8: Characters are returned on `rx_dout` in arrival order. Data bits above the configured length are stored as 0: `char_len` 00 keeps 5 bits, 01 keeps 6, 10 keeps 7 and 11 keeps 8.
- R9: A change of `fifo_mode` empties the receive queue and its error count. Any push or pop in that cycle is ignored.
- R10: After reset the status word is 0x20 ORed with bit 6 as defined by R6, and `thre_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects queued mode, 0 selects character mode |
| char_len | input | 2 | Character length code |
| rx_valid | input | 1 | Receiver has a finished character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error tag |
| rx_ferr | input | 1 | Missing stop bit tag |
| rx_brk | input | 1 | Break (silent line) tag |
| rbr_rd | input | 1 | CPU reads the receive character |
| lsr_rd | input | 1 | CPU reads the status word |
| thr_wr | input | 1 | CPU writes a transmit character |
| thr_to_tsr | input | 1 | Holding register moved into the shift register |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| ier_thre | input | 1 | Transmit-empty interrupt enable |
| lsr | output | 8 | Line status word |
| rx_dout | output | 8 | Character at the head of the queue |
| thre_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The hardest state to reach is an errored character that sits behind a clean one in queued mode. In that state bit 7 must already be set while bits 2 to 4 are still clear. After the clean character is popped, those bits must pick up the newly exposed head's tags, and bit 7 must survive status reads until that entry leaves. The stimulus queues a clean character, then a parity-tagged one and a break-tagged one. It then interleaves receive reads and status reads, and finally fills all sixteen entries to provoke an overrun at the queue's edge.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef struct packed {
    logic perr;
    logic ferr;
    logic brk;
  } err_tag_t;

  typedef struct packed {
    logic [7:0] data;
    err_tag_t   tag;
  } rx_entry_t;

  // Keep the low 5..8 bits depending on the length code.
  function automatic logic [7:0] len_mask(input logic [1:0] code);
    return 8'hFF >> (2'd3 - code);
  endfunction

  function automatic logic tag_any(input err_tag_t t);
    return t.perr | t.ferr | t.brk;
  endfunction
endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       flush,
  input  logic       push_req,
  input  logic [7:0] push_data,
  input  err_tag_t   push_tag,
  input  logic       pop_req,
  output logic [7:0] head_data,
  output logic       head_evt,
  output err_tag_t   head_tag_nxt,
  output logic       overrun_evt,
  output logic       not_empty,
  output logic       full,
  output logic       err_any_nxt
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   DEPTH_C = DEPTH[AW:0];
  localparam logic [AW:0]   CNT_ONE = 1;
  localparam logic [AW-1:0] PTR_ONE = 1;

  rx_entry_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count, count_nxt;
  logic [AW:0]   err_cnt, err_cnt_nxt;
  logic          push, pop;

  always_comb begin
    full        = fifo_mode ? (count == DEPTH_C) : (count != '0);
    push        = push_req & ~full & ~flush;
    overrun_evt = push_req & full & ~flush;
    pop         = pop_req & (count != '0) & ~flush;
    not_empty   = (count != '0);
    head_data   = mem[rd_ptr].data;
    head_evt    = (push & (count == '0)) | (pop & ((count > CNT_ONE) | push));
    head_tag_nxt = (count > CNT_ONE) ? mem[rd_ptr + PTR_ONE].tag : push_tag;
  end

  always_comb begin
    if (flush) begin
      count_nxt   = '0;
      err_cnt_nxt = '0;
    end else begin
      count_nxt   = count;
      err_cnt_nxt = err_cnt;
      if (push) begin
        count_nxt = count_nxt + CNT_ONE;
        if (tag_any(push_tag)) err_cnt_nxt = err_cnt_nxt + CNT_ONE;
      end
      if (pop) begin
        count_nxt = count_nxt - CNT_ONE;
        if (tag_any(mem[rd_ptr].tag)) err_cnt_nxt = err_cnt_nxt - CNT_ONE;
      end
    end
    err_any_nxt = (err_cnt_nxt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      count   <= count_nxt;
      err_cnt <= err_cnt_nxt;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push) wr_ptr <= wr_ptr + PTR_ONE;
        if (pop)  rd_ptr <= rd_ptr + PTR_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= '{data: push_data, tag: push_tag};
  end
endmodule

// File: rtl/lsr_flags.sv
module lsr_flags
  import lsr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fifo_mode,
  input  logic     lsr_rd,
  input  logic     overrun_evt,
  input  logic     head_evt,
  input  err_tag_t head_tag,
  input  logic     err_any_nxt,
  output logic     oe,
  output logic     pe,
  output logic     fe,
  output logic     bi,
  output logic     rx_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe     <= 1'b0;
      pe     <= 1'b0;
      fe     <= 1'b0;
      bi     <= 1'b0;
      rx_err <= 1'b0;
    end else begin
      oe <= overrun_evt | (oe & ~lsr_rd);
      pe <= (head_evt & head_tag.perr) | (pe & ~lsr_rd);
      fe <= (head_evt & head_tag.ferr) | (fe & ~lsr_rd);
      bi <= (head_evt & head_tag.brk)  | (bi & ~lsr_rd);
      if (!fifo_mode)       rx_err <= 1'b0;
      else if (err_any_nxt) rx_err <= 1'b1;
      else if (lsr_rd)      rx_err <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_empty_ctrl.sv
module tx_empty_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic thr_wr,
  input  logic thr_to_tsr,
  input  logic tx_fifo_empty,
  input  logic tsr_empty,
  input  logic ier_thre,
  output logic thre,
  output logic temt,
  output logic irq,
  output logic thre_rise
);
  logic txe_q;
  logic set_c;

  always_comb begin
    set_c     = fifo_mode ? (tx_fifo_empty & ~txe_q) : thr_to_tsr;
    thre_rise = set_c & ~thre & ~thr_wr;
    temt      = tsr_empty & (fifo_mode ? tx_fifo_empty : thre);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q <= 1'b1;
      thre  <= 1'b1;
      irq   <= 1'b0;
    end else begin
      txe_q <= tx_fifo_empty;
      if (thr_wr)     thre <= 1'b0;
      else if (set_c) thre <= 1'b1;
      if (!ier_thre || thr_wr) irq <= 1'b0;
      else if (thre_rise)      irq <= 1'b1;
    end
  end
endmodule

// File: rtl/lsr_unit.sv
module lsr_unit
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic [1:0] char_len,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       rbr_rd,
  input  logic       lsr_rd,
  input  logic       thr_wr,
  input  logic       thr_to_tsr,
  input  logic       tx_fifo_empty,
  input  logic       tsr_empty,
  input  logic       ier_thre,
  output logic [7:0] lsr,
  output logic [7:0] rx_dout,
  output logic       thre_irq
);
  logic     mode_q, flush;
  logic     head_evt, overrun_evt, not_empty, rx_full, err_any_nxt;
  err_tag_t in_tag, head_tag;
  logic     oe, pe, fe, bi, rx_err, thre, temt, thre_rise;

  assign flush  = fifo_mode ^ mode_q;
  assign in_tag = '{perr: rx_perr, ferr: rx_ferr, brk: rx_brk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end

  rx_tag_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .flush(flush),
    .push_req(rx_valid), .push_data(rx_data & len_mask(char_len)),
    .push_tag(in_tag), .pop_req(rbr_rd), .head_data(rx_dout),
    .head_evt(head_evt), .head_tag_nxt(head_tag), .overrun_evt(overrun_evt),
    .not_empty(not_empty), .full(rx_full), .err_any_nxt(err_any_nxt)
  );

  lsr_flags flags_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .lsr_rd(lsr_rd),
    .overrun_evt(overrun_evt), .head_evt(head_evt), .head_tag(head_tag),
    .err_any_nxt(err_any_nxt), .oe(oe), .pe(pe), .fe(fe), .bi(bi),
    .rx_err(rx_err)
  );

  tx_empty_ctrl tx_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .thr_wr(thr_wr),
    .thr_to_tsr(thr_to_tsr), .tx_fifo_empty(tx_fifo_empty),
    .tsr_empty(tsr_empty), .ier_thre(ier_thre), .thre(thre), .temt(temt),
    .irq(thre_irq), .thre_rise(thre_rise)
  );

  assign lsr = {rx_err, temt, thre, bi, fe, pe, oe, not_empty};
endmodule

// File: rtl/lsr_unit_chk.sv
module lsr_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_mode,
  input logic       rx_valid,
  input logic       lsr_rd,
  input logic       thr_wr,
  input logic       tsr_empty,
  input logic       ier_thre,
  input logic [7:0] lsr,
  input logic       thre_irq,
  input logic       rx_full,
  input logic       flush,
  input logic       head_evt
);
  assert_dr_on_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_full && !flush) |=> lsr[0]);
  assert_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !flush) |=> lsr[1]);
  assert_rd_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !head_evt) |=> (lsr[4:2] == 3'b000));
  assert_bit7_char_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fifo_mode) |-> !lsr[7]);
  assert_wr_clears_thre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !lsr[5]);
  assert_temt_needs_tsr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> tsr_empty);
  assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_thre || thr_wr) |=> !thre_irq);
endmodule

bind lsr_unit lsr_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_valid(rx_valid),
  .lsr_rd(lsr_rd), .thr_wr(thr_wr), .tsr_empty(tsr_empty),
  .ier_thre(ier_thre), .lsr(lsr), .thre_irq(thre_irq), .rx_full(rx_full),
  .flush(flush), .head_evt(head_evt)
);

// File: tb/lsr_unit_tb_top.sv
`timescale 1ns/1ps
module lsr_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_mode = 0, rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic rbr_rd = 0, lsr_rd = 0, thr_wr = 0, thr_to_tsr = 0;
  logic tx_fifo_empty = 1, tsr_empty = 1, ier_thre = 0;
  logic [1:0] char_len = 2'b11;
  logic [7:0] rx_data = 0;
  logic [7:0] lsr, rx_dout;
  logic thre_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [10:0] exp_q[$];        // {data, perr, ferr, brk}
  bit m_oe, m_pe, m_fe, m_bi, m_e7, m_thre = 1, m_irq, m_txe = 1, m_mode;

  always #2 clk = ~clk;

  lsr_unit dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic string bit_req(input int b);
    case (b)
      0: return "R1";
      1: return "R2";
      5: return "R5";
      6: return "R6";
      7: return "R4";
      default: return "R3";
    endcase
  endfunction

  // one clock: apply the requirements to the reference, then compare
  task automatic step();
    int n;
    bit full, push, pop, hev, setc, rise;
    logic [10:0] inc, hd;
    logic [7:0] ev;
    @(posedge clk);
    n = exp_q.size();
    inc = {rx_data & (8'hFF >> (2'd3 - char_len)), rx_perr, rx_ferr, rx_brk};
    if (fifo_mode != m_mode) begin                  // R9
      exp_q.delete();
      push = 0; pop = 0; hev = 0; full = 0;
      m_oe = m_oe & ~lsr_rd;
      hd = '0;
    end else begin
      full = (n == (fifo_mode ? 16 : 1));
      push = rx_valid & ~full;
      pop  = rbr_rd & (n > 0);
      hev  = (push & (n == 0)) | (pop & ((n > 1) | push));
      hd   = (n > 1) ? exp_q[1] : inc;
      m_oe = (rx_valid & full) | (m_oe & ~lsr_rd);
    end
    m_pe = (hev & hd[2]) | (m_pe & ~lsr_rd);
    m_fe = (hev & hd[1]) | (m_fe & ~lsr_rd);
    m_bi = (hev & hd[0]) | (m_bi & ~lsr_rd);
    if (pop) void'(exp_q.pop_front());
    if (push) exp_q.push_back(inc);
    n = 0;
    foreach (exp_q[i]) if (exp_q[i][2:0] != 0) n++;
    if (!fifo_mode) m_e7 = 0;
    else if (n != 0) m_e7 = 1;
    else if (lsr_rd) m_e7 = 0;
    m_mode = fifo_mode;
    setc = fifo_mode ? (tx_fifo_empty & ~m_txe) : thr_to_tsr;
    rise = setc & ~m_thre & ~thr_wr;
    if (thr_wr) m_thre = 0; else if (setc) m_thre = 1;
    if (!ier_thre || thr_wr) m_irq = 0; else if (rise) m_irq = 1;
    m_txe = tx_fifo_empty;
    #1;
    ev = {m_e7, tsr_empty & (fifo_mode ? tx_fifo_empty : m_thre), m_thre,
          m_bi, m_fe, m_pe, m_oe, exp_q.size() > 0};
    for (int b = 0; b < 8; b++) check(bit_req(b), {7'd0, lsr[b]}, {7'd0, ev[b]});
    check("R7", {7'd0, thre_irq}, {7'd0, m_irq});
    if (exp_q.size() > 0) check("R8", rx_dout, exp_q[0][10:3]);  // scoreboard
    @(negedge clk);
    rx_valid = 0; rbr_rd = 0; lsr_rd = 0; thr_wr = 0; thr_to_tsr = 0;
    rx_perr = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  task automatic rx(input logic [7:0] d, input bit p, input bit f, input bit b);
    rx_valid = 1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    step();
  endtask
  task automatic rd_rx();  rbr_rd = 1; step(); endtask
  task automatic rd_lsr(); lsr_rd = 1; step(); endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", lsr, 8'h60);
    check("R10", {7'd0, thre_irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    // character mode: data ready, masking (R1, R8)
    rx(8'hA5, 0, 0, 0);
    rd_rx();
    char_len = 2'b00; rx(8'hFF, 0, 0, 0);
    check("R8", rx_dout, 8'h1F);
    rd_rx();
    char_len = 2'b10; rx(8'hFF, 0, 0, 0); rd_rx();
    char_len = 2'b11;
    // overrun in one-deep buffer (R2)
    rx(8'h11, 0, 0, 0); rx(8'h22, 0, 0, 0);
    check("R2", rx_dout, 8'h11);
    rd_lsr(); rd_rx();
    // error tags and clear-by-read, set wins (R3)
    rx(8'h33, 1, 0, 0); rd_lsr();
    rd_rx();
    rx_valid = 1; rx_data = 8'h44; rx_brk = 1; lsr_rd = 1; step();
    check("R3", {7'd0, lsr[4]}, 8'h01);
    rd_rx(); rx(8'h55, 0, 1, 0); rd_rx(); rd_lsr();
    // transmit side, character mode (R5, R6, R7)
    ier_thre = 1;
    thr_wr = 1; tsr_empty = 0; step();
    check("R5", {7'd0, lsr[5]}, 8'h00);
    thr_to_tsr = 1; step();
    check("R7", {7'd0, thre_irq}, 8'h01);
    tsr_empty = 1; step();
    thr_wr = 1; thr_to_tsr = 1; step();
    thr_to_tsr = 1; step();
    ier_thre = 0; step();
    check("R7", {7'd0, thre_irq}, 8'h00);
    // queued mode: errored entry behind a clean one (R4, R3)
    rx(8'h66, 0, 0, 0);
    fifo_mode = 1; step();
    check("R9", {7'd0, lsr[0]}, 8'h00);
    rx(8'h01, 0, 0, 0); rx(8'h02, 1, 0, 0); rx(8'h03, 0, 0, 1);
    check("R4", lsr & 8'h9C, 8'h80);
    rd_rx(); rd_lsr(); rd_lsr();
    rbr_rd = 1; rx_valid = 1; rx_data = 8'h04; step();
    rd_rx(); rd_lsr(); rd_rx(); rd_lsr();
    check("R4", {7'd0, lsr[7]}, 8'h00);
    // fill to depth, overrun at the edge (R2)
    for (int i = 0; i < 17; i++) rx(8'(i + 8'h80), 0, 0, 0);
    check("R2", {7'd0, lsr[1]}, 8'h01);
    for (int i = 0; i < 16; i++) rd_rx();
    rd_lsr();
    // queued-mode transmit (R5, R6, R7)
    ier_thre = 1; thr_wr = 1; tx_fifo_empty = 0; step();
    check("R6", {7'd0, lsr[6]}, 8'h00);
    tx_fifo_empty = 1; step();
    step();
    check("R7", {7'd0, thre_irq}, 8'h01);
    thr_wr = 1; step();
    // mode change with queued errors flushes (R9)
    rx(8'h77, 1, 1, 1); rx(8'h78, 0, 0, 0);
    fifo_mode = 0; step();
    check("R9", lsr & 8'h81, 8'h00);
    rx(8'h79, 0, 0, 0); rd_rx(); rd_lsr();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule